// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block is a small prefetch queue that sits beside a first-level data cache. Every cache access is also presented to the queue in the same cycle, together with the cache's own hit/miss outcome. When the cache misses and the queue cannot supply the line, the queue is flushed. It is then refilled with requests for the DEPTH line addresses that follow the missing one. Prefetched lines live only in the queue, so the cache is never polluted by lines that are never used.

When the cache misses and the oldest entry of the queue holds the wanted line with its data already returned, the queue hands the line to the cache. It then retires that entry and reuses the entry to request the line just past the youngest one. Requests leave one per cycle over a valid/ready handshake. Each request carries an opaque tag, and memory must echo that tag with the fill data. A flush advances a stream counter inside the tag, so fills that belong to a discarded stream are recognised and dropped.

A three-state controller tracks the queue. ST_IDLE means no stream has started since reset. ST_ISSUE means at least one entry still needs its memory request sent. ST_DRAIN means every entry's request has been sent. The transitions are as follows:
- START: ST_IDLE to ST_ISSUE, on a restarting miss.
- RESTART: ST_ISSUE or ST_DRAIN to ST_ISSUE, on a restarting miss.
- REFILL: ST_ISSUE or ST_DRAIN to ST_ISSUE, when an entry is retired.
- LAST_SENT: ST_ISSUE to ST_DRAIN, when the last outstanding request is accepted in a cycle with no restart and no retirement.

In every other cycle the controller holds its state.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset, req_valid is low, and a lookup reports pf_hit low until a stream has been started and filled.
- R2: A lookup with lk_valid=1 and lk_miss=1 that does not hit restarts the stream at lk_addr. The block then requests lines lk_addr+1 up to lk_addr+DEPTH, one per accepted handshake, in strictly ascending order. After those DEPTH requests, req_valid stays low. req_tag is opaque and is returned unchanged on fill_tag.
- R3: While req_valid=1 and req_ready=0, and no restart occurs, req_valid stays high and req_addr does not change.
- R4: pf_hit is high in the cycle of a lookup exactly when lk_addr equals the line address of the oldest entry and that entry's fill has arrived. pf_data then carries the fill_data returned for that line.
- R5: A lookup with lk_miss=1 that hits retires the oldest entry. The next request issued is for the line DEPTH past the hit line, which is one past the previous youngest line.
- R6: A miss on a line held at a non-oldest position, or held at the oldest position with no data yet, reports pf_hit low and restarts the stream at lk_addr.
- R7: A fill whose tag belongs to a flushed stream is discarded, and the entry that reuses that slot reports no hit until its own fill arrives.
- R8: A lookup with lk_miss=0 changes nothing. A hit still reports pf_hit and pf_data, but no entry is retired and no request is issued.
- R9: A fill that arrives in the same cycle as a restarting miss is discarded. A fill that arrives in the same cycle as a retirement of a different entry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A cache access is being looked up this cycle |
| lk_miss | input | 1 | The cache itself missed on this access |
| lk_addr | input | ADDR_W | Line address of the access |
| pf_hit | output | 1 | The oldest queue entry holds this line with data |
| pf_data | output | DATA_W | Line data of the oldest entry |
| req_valid | output | 1 | A line request toward memory is offered |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | ADDR_W | Requested line address |
| req_tag | output | EPOCH_W+IDX_W | Tag to be echoed with the fill |
| fill_valid | input | 1 | Fill data returns this cycle |
| fill_tag | input | EPOCH_W+IDX_W | Tag of the returning request |
| fill_data | input | DATA_W | Returned line data |

## Verification
Two functions can fall in one cycle: a restart or a retirement, and a fill arriving from memory. The bench drives a restarting miss together with a fill for a line of the stream being discarded. It judges the outcome by retiring entries of the new stream until the reused slot becomes the oldest, then probing with lk_miss=0, and pf_hit must stay low. It also retires one entry while a fill lands in the next one, and requires both the refill request and a later hit on the filled line.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN
    } spf_state_e;
endpackage

// File: rtl/spf_slots.sv
module spf_slots #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           restart,
    input  logic [ADDR_W-1:0]              base_addr,
    input  logic                           pop,
    input  logic [IDX_W-1:0]               head_idx,
    input  logic                           fill_we,
    input  logic [IDX_W-1:0]               fill_idx,
    input  logic [DATA_W-1:0]              fill_data,
    input  logic                           issue_we,
    input  logic [IDX_W-1:0]               issue_idx,
    output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]   slot_data,
    output logic [DEPTH-1:0]               slot_valid,
    output logic [DEPTH-1:0]               slot_ready,
    output logic [DEPTH-1:0]               slot_issued
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr[i]   <= '0;
                slot_data[i]   <= '0;
                slot_valid[i]  <= 1'b0;
                slot_ready[i]  <= 1'b0;
                slot_issued[i] <= 1'b0;
            end else if (restart) begin
                slot_addr[i]   <= base_addr + ADDR_W'(i + 1);
                slot_valid[i]  <= 1'b1;
                slot_ready[i]  <= 1'b0;
                slot_issued[i] <= 1'b0;
            end else if (pop && head_idx == IDX_W'(i)) begin
                slot_addr[i]   <= slot_addr[i] + ADDR_W'(DEPTH);
                slot_ready[i]  <= 1'b0;
                slot_issued[i] <= 1'b0;
            end else begin
                if (fill_we && fill_idx == IDX_W'(i)) begin
                    slot_ready[i] <= 1'b1;
                    slot_data[i]  <= fill_data;
                end
                if (issue_we && issue_idx == IDX_W'(i)) begin
                    slot_issued[i] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 2,
    parameter int EPOCH_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          restart,
    input  logic [IDX_W-1:0]              head_idx,
    input  logic [EPOCH_W-1:0]            epoch,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    input  logic [DEPTH-1:0]              slot_valid,
    input  logic [DEPTH-1:0]              slot_issued,
    input  logic                          req_ready,
    output logic                          req_valid,
    output logic [ADDR_W-1:0]             req_addr,
    output logic [EPOCH_W+IDX_W-1:0]      req_tag,
    output logic                          issue_we,
    output logic [IDX_W-1:0]              issue_idx
);
    logic found;
    logic [IDX_W-1:0] pick;

    // oldest entry whose request has not yet left, scanning from the head
    always_comb begin
        int j;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            j = int'(head_idx) + k;
            if (j >= DEPTH) j = j - DEPTH;
            if (!found && slot_valid[j] && !slot_issued[j]) begin
                found = 1'b1;
                pick  = IDX_W'(j);
            end
        end
    end

    always_comb begin
        req_valid = enable && found;
        req_addr  = slot_addr[pick];
        req_tag   = {epoch, pick};
        issue_we  = req_valid && req_ready;
        issue_idx = pick;
    end

    // R3: a stalled request holds its address until accepted or flushed
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !restart |=> req_valid && $stable(req_addr));
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int DEPTH   = 4,
    parameter int EPOCH_W = 2,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int TAG_W  = EPOCH_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_miss,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              pf_hit,
    output logic [DATA_W-1:0] pf_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [TAG_W-1:0]  req_tag,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    import spf_pkg::*;

    spf_state_e state_q, state_d;
    logic [IDX_W-1:0]   head_q;
    logic [EPOCH_W-1:0] epoch_q;

    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic [DEPTH-1:0] slot_valid, slot_ready, slot_issued;

    logic head_hit, pop, restart, fill_ok, issue_we;
    logic [IDX_W-1:0] issue_idx, fill_idx;
    logic [EPOCH_W-1:0] fill_epoch;
    logic [IDX_W:0] pend_cnt;

    assign fill_idx   = fill_tag[IDX_W-1:0];
    assign fill_epoch = fill_tag[TAG_W-1:IDX_W];

    // outputs and per-cycle decisions
    always_comb begin
        head_hit = lk_valid && slot_valid[head_q] && slot_ready[head_q]
                   && slot_addr[head_q] == lk_addr;
        pf_hit   = head_hit;
        pf_data  = slot_data[head_q];
        pop      = head_hit && lk_miss;
        restart  = lk_valid && lk_miss && !head_hit;
        fill_ok  = fill_valid && !restart && fill_epoch == epoch_q
                   && int'(fill_idx) < DEPTH && slot_valid[fill_idx]
                   && slot_issued[fill_idx] && !slot_ready[fill_idx];
        pend_cnt = '0;
        for (int k = 0; k < DEPTH; k++) begin
            pend_cnt = pend_cnt + (IDX_W+1)'(slot_valid[k] && !slot_issued[k]);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (restart) state_d = ST_ISSUE;
            ST_ISSUE: if (restart || pop) state_d = ST_ISSUE;
                      else if (issue_we && pend_cnt == (IDX_W+1)'(1)) state_d = ST_DRAIN;
            ST_DRAIN: if (restart || pop) state_d = ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            head_q  <= '0;
            epoch_q <= '0;
        end else begin
            state_q <= state_d;
            if (restart) begin
                head_q  <= '0;
                epoch_q <= epoch_q + 1'b1;
            end else if (pop) begin
                head_q <= (head_q == IDX_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
            end
        end
    end

    spf_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .restart(restart), .base_addr(lk_addr),
        .pop(pop), .head_idx(head_q), .fill_we(fill_ok), .fill_idx(fill_idx),
        .fill_data(fill_data), .issue_we(issue_we), .issue_idx(issue_idx),
        .slot_addr(slot_addr), .slot_data(slot_data), .slot_valid(slot_valid),
        .slot_ready(slot_ready), .slot_issued(slot_issued)
    );

    spf_issue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .EPOCH_W(EPOCH_W)) u_issue (
        .clk(clk), .rst_n(rst_n), .enable(state_q == ST_ISSUE), .restart(restart),
        .head_idx(head_q), .epoch(epoch_q), .slot_addr(slot_addr),
        .slot_valid(slot_valid), .slot_issued(slot_issued), .req_ready(req_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag),
        .issue_we(issue_we), .issue_idx(issue_idx)
    );

    // checker state: last line requested in the current stream
    logic [ADDR_W-1:0] chk_last;
    logic              chk_have;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_last <= '0;
            chk_have <= 1'b0;
        end else if (restart) begin
            chk_last <= lk_addr;
            chk_have <= 1'b1;
        end else if (issue_we) begin
            chk_last <= req_addr;
        end
    end

    // R1: nothing is offered or hit before the first stream
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !req_valid && !pf_hit);
    // R2 and R5: every accepted request is one line past the previous one
    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        issue_we && chk_have && !restart |-> req_addr == chk_last + 1'b1);
    // R5: retiring an entry always leaves a request to send
    a_r5_refill: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> state_q == ST_ISSUE && req_valid);
    // R6: a restart offers a fresh request in the next cycle
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> req_valid && req_addr == $past(lk_addr) + 1'b1);
endmodule

// File: tb/stream_prefetcher_bench.sv
`timescale 1ns/1ps
module stream_prefetcher_bench;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int D  = 4;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic lk_valid, lk_miss;
    logic [AW-1:0] lk_addr;
    logic pf_hit;
    logic [DW-1:0] pf_data;
    logic req_valid, req_ready;
    logic [AW-1:0] req_addr;
    logic [TW-1:0] req_tag;
    logic fill_valid;
    logic [TW-1:0] fill_tag;
    logic [DW-1:0] fill_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [AW-1:0] cap_addr [64];
    logic [TW-1:0] cap_tag  [64];
    int cap_n = 0;

    always #4 clk = ~clk;

    stream_prefetcher #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(D), .EPOCH_W(2)) u_stream_prefetcher (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_miss(lk_miss),
        .lk_addr(lk_addr), .pf_hit(pf_hit), .pf_data(pf_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_tag(req_tag), .fill_valid(fill_valid), .fill_tag(fill_tag),
        .fill_data(fill_data)
    );

    function automatic logic [DW-1:0] line_data(input logic [AW-1:0] a);
        return {a ^ 32'h5A5A_C3C3, a};
    endfunction

    function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
        for (int i = cap_n - 1; i >= 0; i--) if (cap_addr[i] == a) return cap_tag[i];
        return '0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic miss, output logic hit,
                         output logic [DW-1:0] data);
        @(negedge clk);
        lk_valid = 1'b1; lk_miss = miss; lk_addr = a;
        #1 hit = pf_hit; data = pf_data;
        @(negedge clk);
        lk_valid = 1'b0; lk_miss = 1'b0;
    endtask

    task automatic expect_hit(input logic [AW-1:0] a, input logic miss, input string req);
        logic h; logic [DW-1:0] d;
        probe(a, miss, h, d);
        check(h == 1'b1, req, DW'(h), 1);
        check(d == line_data(a), req, d, line_data(a));
    endtask

    task automatic expect_nohit(input logic [AW-1:0] a, input logic miss, input string req);
        logic h; logic [DW-1:0] d;
        probe(a, miss, h, d);
        check(h == 1'b0, req, DW'(h), 0);
    endtask

    task automatic accept(input int n, input logic [AW-1:0] first, input bit then_idle,
                          input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_ready = 1'b1;
            #1;
            check(req_valid == 1'b1, req, DW'(req_valid), 1);
            check(req_addr == first + AW'(i), req, DW'(req_addr), DW'(first + AW'(i)));
            cap_addr[cap_n] = req_addr; cap_tag[cap_n] = req_tag; cap_n++;
        end
        @(negedge clk);
        req_ready = 1'b0;
        #1;
        if (then_idle) check(req_valid == 1'b0, req, DW'(req_valid), 0);
    endtask

    task automatic fill_line(input logic [AW-1:0] a);
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = tag_of(a); fill_data = line_data(a);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check(req_valid == 1'b0, "R1 reset req_valid", DW'(req_valid), 0);
        expect_nohit(32'h0000_0001, 1'b0, "R1 no hit after reset");
        #1 check(req_valid == 1'b0, "R1 quiet after probe", DW'(req_valid), 0);
    endtask

    task automatic t_start_and_stall;
        logic h; logic [DW-1:0] d;
        probe(32'h100, 1'b1, h, d);
        check(h == 1'b0, "R2 restart miss no hit", DW'(h), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check(req_valid && req_addr == 32'h101, "R3 stalled request held",
                  DW'(req_addr), 64'h101);
        end
        accept(D, 32'h101, 1'b1, "R2 ascending burst");
    endtask

    task automatic t_hit_rules;
        fill_line(32'h103);
        expect_nohit(32'h101, 1'b0, "R4 head without data");
        expect_nohit(32'h103, 1'b0, "R4 ready but not head");
        fill_line(32'h101);
        expect_hit(32'h101, 1'b0, "R8 hit reported without pop");
        expect_hit(32'h101, 1'b0, "R8 head kept after cache hit");
        #1 check(req_valid == 1'b0, "R8 no request from cache hit", DW'(req_valid), 0);
    endtask

    task automatic t_pop;
        expect_hit(32'h101, 1'b1, "R4 pop returns line");
        accept(1, 32'h105, 1'b1, "R5 refill one past tail");
        expect_nohit(32'h102, 1'b0, "R4 new head not ready");
        fill_line(32'h102);
        fill_line(32'h104);
        fill_line(32'h105);
        expect_hit(32'h102, 1'b1, "R5 second pop");
        accept(1, 32'h106, 1'b1, "R5 refill 0x106");
    endtask

    task automatic t_nonhead_and_stale;
        logic [TW-1:0] old_tag;
        old_tag = tag_of(32'h106);
        expect_nohit(32'h104, 1'b1, "R6 non-head match is a miss");
        accept(D, 32'h105, 1'b1, "R6 restart after non-head match");
        @(negedge clk);
        fill_valid = 1'b1; fill_tag = old_tag; fill_data = 64'hDEAD_BEEF_DEAD_BEEF;
        @(negedge clk);
        fill_valid = 1'b0;
        fill_line(32'h105);
        expect_hit(32'h105, 1'b1, "R7 new head hit");
        accept(1, 32'h109, 1'b1, "R5 refill 0x109");
        expect_nohit(32'h106, 1'b0, "R7 stale fill discarded");
        fill_line(32'h106);
        expect_hit(32'h106, 1'b0, "R7 own fill accepted");
    endtask

    task automatic t_same_cycle;
        logic h; logic [DW-1:0] d;
        @(negedge clk);
        lk_valid = 1'b1; lk_miss = 1'b1; lk_addr = 32'h200;
        fill_valid = 1'b1; fill_tag = tag_of(32'h107); fill_data = line_data(32'h203);
        #1 check(pf_hit == 1'b0, "R9 restart miss", DW'(pf_hit), 0);
        @(negedge clk);
        lk_valid = 1'b0; lk_miss = 1'b0; fill_valid = 1'b0;
        accept(D, 32'h201, 1'b1, "R9 burst after restart with fill");
        fill_line(32'h201);
        @(negedge clk);
        lk_valid = 1'b1; lk_miss = 1'b1; lk_addr = 32'h201;
        fill_valid = 1'b1; fill_tag = tag_of(32'h202); fill_data = line_data(32'h202);
        #1 h = pf_hit; d = pf_data;
        check(h == 1'b1 && d == line_data(32'h201), "R9 pop with fill", d, line_data(32'h201));
        @(negedge clk);
        lk_valid = 1'b0; lk_miss = 1'b0; fill_valid = 1'b0;
        accept(1, 32'h205, 1'b1, "R9 refill during fill");
        expect_hit(32'h202, 1'b0, "R9 fill kept during pop");
        expect_hit(32'h202, 1'b1, "R5 pop 0x202");
        accept(1, 32'h206, 1'b1, "R5 refill 0x206");
        expect_nohit(32'h203, 1'b0, "R9 fill dropped on restart");
        expect_nohit(32'h203, 1'b1, "R6 head without data restarts");
        accept(1, 32'h204, 1'b0, "R6 restart at head address");
    endtask

    initial begin
        rst_n = 1'b0;
        lk_valid = 1'b0; lk_miss = 1'b0; lk_addr = '0;
        req_ready = 1'b0; fill_valid = 1'b0; fill_tag = '0; fill_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_start_and_stall();
        t_hit_rules();
        t_pop();
        t_nonhead_and_stale();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule